// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block holds a set of programmable 32-bit event counters and one free-running cycle counter at index 31. Software reaches it through a flat register port with one write per cycle and a combinational read. Each event counter advances on its own event pulse input. A software-increment register can also bump counters that are programmed with the software-increment event code. Every counter raises a one-cycle wrap strobe toward the overflow logic when it rolls over.

Two neighbouring counters, an even one and the odd one above it, can act as one 64-bit counter. The even counter holds the low word and the odd counter holds the high word. The odd counter then advances only on the carry out of its partner. The cycle counter is 32 or 64 bits wide, chosen by a control bit. A count field in the control register limits which event counters exist from the point of view of software.

Register map (7-bit address): 0x00 control, 0x01 enable-set, 0x02 enable-clear, 0x03 software increment, 0x20+i event type of counter i, 0x40+i value of counter i (0x5F is the low word of the cycle counter), 0x60 high word of the cycle counter. Control fields are: bit 0 run, bit 1 clear event counters (write-only action), bit 2 clear cycle counter (write-only action), bit 3 long cycle mode, bits 8:4 implemented count N.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, control reads 0x000001F0 (run clear, long mode clear, N = 31), the enable register reads 0, all counters and event types read 0, and wrap_o is 0.
- R2: A write to an event-type register keeps only the low 16 bits (10 bits when WIDE_EVT is 0); the upper bits read back as zero.
- R3: Writing 1s to the enable-set address sets those enable bits, and writing 1s to the enable-clear address clears them. Both addresses read the enable bits of valid counters.
- R4: While run (control bit 0) is clear, no counter advances on events, software increments or cycles, and wrap_o stays 0.
- R5: A software-increment write advances counter i (i < 31) only when run is set, bit i of the write is 1, counter i is enabled, and its event type is 0x0000. Event pulses count on an enabled counter whatever its type.
- R6: An unchained event counter that rolls from 0xFFFFFFFF to 0 raises its own bit of wrap_o for exactly the one cycle after the rollover edge.
- R7: An event pulse and a software increment that reach the same counter in the same cycle both count, so the counter advances by two.
- R8: Pair (2k, 2k+1) is chained only while run is set, counter 2k+1 is enabled, and counter 2k+1 has event type 0x001E.
- R9: In a chained pair the even counter is the low word and the odd counter is the high word. The odd counter ignores its own pulse and advances only on a carry from the even counter. The even counter raises no wrap strobe, and a rollover of the full 64-bit value strobes the odd index.
- R10: The cycle counter advances once per cycle while run and enable bit 31 are set. With long mode set it is one 64-bit count and strobes bit 31 on a 64-bit rollover. With long mode clear only the low word counts, the high word is held, and bit 31 strobes on a 32-bit rollover.
- R11: A control write with bit 1 set clears every valid event counter and leaves the cycle counter unchanged. A control write with bit 2 set clears the cycle counter.
- R12: Event counter i is valid only when i < N. The cycle counter is always valid, so N = 0 leaves only the cycle counter. Counters that are not valid read 0 in value and type, ignore writes, and never count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 32 | Combinational read data |
| evt_i | input | 31 | Per-counter event pulses, one per cycle at most |
| wrap_o | output | 32 | Per-counter one-cycle wrap strobes, bit 31 is the cycle counter |

## Verification
The assertions assume three things. A register write takes effect at the edge where wr_en is sampled. Any load or clear on an edge cancels that edge's rollover strobe. The count field is taken as given, so counters beyond it can never strobe. The stimulus changes wr_en, the address, the data and evt_i only on falling edges and keeps every pulse to one cycle. It also changes enables only while the affected counter is idle, or at known edges, so the edge on which each rollover lands is fixed.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int CYC_IDX = 31;
    localparam int SLOTS   = CYC_IDX + 1;
    localparam int NPAIR   = CYC_IDX / 2;
    localparam int NUM_W   = 5;

    localparam logic [15:0] EVT_SWINC = 16'h0000;
    localparam logic [15:0] EVT_CHAIN = 16'h001E;

    typedef enum logic [1:0] {
        GRP_MISC = 2'b00,
        GRP_TYPE = 2'b01,
        GRP_CNT  = 2'b10,
        GRP_HI   = 2'b11
    } reg_grp_e;

    typedef struct packed {
        logic [NUM_W-1:0] num;
        logic             long_cyc;
        logic             run;
    } ctrl_t;

    typedef struct packed {
        logic             ctrl;
        logic             en_set;
        logic             en_clr;
        logic             swinc;
        logic             type_w;
        logic             cnt_w;
        logic             cyc_hi;
        logic [NUM_W-1:0] idx;
    } wr_dec_t;

    function automatic int evt_width(input bit wide);
        return wide ? 16 : 10;
    endfunction

    function automatic logic [SLOTS-1:0] impl_mask(input int impl);
        logic [SLOTS-1:0] m;
        for (int i = 0; i < SLOTS; i++)
            m[i] = (i == CYC_IDX) || (i < impl);
        return m;
    endfunction

    function automatic logic [SLOTS-1:0] valid_mask(input logic [NUM_W-1:0] n, input int impl);
        logic [SLOTS-1:0] m;
        for (int i = 0; i < SLOTS; i++)
            m[i] = (i == CYC_IDX) || ((i < int'(n)) && (i < impl));
        return m;
    endfunction

    function automatic wr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        wr_dec_t  d;
        reg_grp_e g;
        g     = reg_grp_e'(a[6:5]);
        d     = '0;
        d.idx = a[4:0];
        case (g)
            GRP_MISC: begin
                d.ctrl   = (a[4:0] == 5'd0);
                d.en_set = (a[4:0] == 5'd1);
                d.en_clr = (a[4:0] == 5'd2);
                d.swinc  = (a[4:0] == 5'd3);
            end
            GRP_TYPE: d.type_w = 1'b1;
            GRP_CNT:  d.cnt_w  = 1'b1;
            GRP_HI:   d.cyc_hi = (a[4:0] == 5'd0);
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/evt_ctr_regs.sv
module evt_ctr_regs
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR = 31,
    parameter int EVT_W   = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    output ctrl_t                         ctl,
    output logic [SLOTS-1:0]              en_q,
    output logic [SLOTS-1:0]              valid,
    output logic [SLOTS-1:0]              en_eff,
    output logic [SLOTS-1:0][EVT_W-1:0]   type_q,
    output logic [CYC_IDX-1:0]            sw_hit,
    output logic [NPAIR-1:0]              chained,
    output logic                          clr_evt,
    output logic                          clr_cyc,
    output logic [SLOTS-1:0]              cnt_wr,
    output logic                          cyc_hi_wr
);

    localparam logic [SLOTS-1:0] IMPL = impl_mask(NUM_CTR);
    localparam logic [EVT_W-1:0] SWINC_CODE = EVT_SWINC[EVT_W-1:0];
    localparam logic [EVT_W-1:0] CHAIN_CODE = EVT_CHAIN[EVT_W-1:0];

    wr_dec_t dec;
    assign dec = decode_addr(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.run      <= 1'b0;
            ctl.long_cyc <= 1'b0;
            ctl.num      <= NUM_W'(NUM_CTR);
        end else if (wr_en && dec.ctrl) begin
            ctl.run      <= wr_data[0];
            ctl.long_cyc <= wr_data[3];
            ctl.num      <= wr_data[8:4];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_en && dec.en_set)
            en_q <= en_q | (wr_data & IMPL);
        else if (wr_en && dec.en_clr)
            en_q <= en_q & ~wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++)
                type_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_CTR; i++)
                if (wr_en && dec.type_w && (dec.idx == NUM_W'(i)) && valid[i])
                    type_q[i] <= wr_data[EVT_W-1:0];
        end
    end

    assign valid  = valid_mask(ctl.num, NUM_CTR);
    assign en_eff = ctl.run ? (en_q & valid) : '0;

    always_comb begin
        for (int i = 0; i < CYC_IDX; i++)
            sw_hit[i] = wr_en && dec.swinc && wr_data[i] && en_eff[i]
                        && (type_q[i] == SWINC_CODE);
        for (int k = 0; k < NPAIR; k++)
            chained[k] = en_eff[2*k+1] && (type_q[2*k+1] == CHAIN_CODE);
        for (int i = 0; i < SLOTS; i++)
            cnt_wr[i] = wr_en && dec.cnt_w && (dec.idx == NUM_W'(i)) && valid[i];
    end

    assign clr_evt   = wr_en && dec.ctrl && wr_data[1];
    assign clr_cyc   = wr_en && dec.ctrl && wr_data[2];
    assign cyc_hi_wr = wr_en && dec.cyc_hi;

endmodule

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice
    import evt_ctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              count_en,
    input  logic              evt,
    input  logic              sw_hit,
    input  logic              link_hi,
    input  logic              link_lo,
    input  logic              carry_in,
    input  logic              load,
    input  logic              clear,
    input  logic [WORD_W-1:0] load_val,
    output logic [WORD_W-1:0] value,
    output logic              carry_out,
    output logic              wrap_q
);

    logic [1:0]      step;
    logic [WORD_W:0] sum;

    always_comb begin
        if (link_hi)
            step = {1'b0, carry_in};
        else if (count_en)
            step = {1'b0, evt} + {1'b0, sw_hit};
        else
            step = 2'd0;
        sum       = {1'b0, value} + {{(WORD_W-1){1'b0}}, step};
        carry_out = sum[WORD_W] && !load && !clear;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value  <= '0;
            wrap_q <= 1'b0;
        end else begin
            if (clear)
                value <= '0;
            else if (load)
                value <= load_val;
            else
                value <= sum[WORD_W-1:0];
            wrap_q <= carry_out && !link_lo;
        end
    end

endmodule

// File: rtl/evt_ctr_cycle.sv
module evt_ctr_cycle
    import evt_ctr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                count_en,
    input  logic                long_mode,
    input  logic                load_lo,
    input  logic                load_hi,
    input  logic                clear,
    input  logic [WORD_W-1:0]   load_val,
    output logic [2*WORD_W-1:0] value,
    output logic                wrap_q
);

    logic [WORD_W:0] lo_sum;
    logic [WORD_W:0] hi_sum;

    assign lo_sum = {1'b0, value[WORD_W-1:0]} + {{WORD_W{1'b0}}, 1'b1};
    assign hi_sum = {1'b0, value[2*WORD_W-1:WORD_W]} + {{WORD_W{1'b0}}, lo_sum[WORD_W]};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            value  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (count_en) begin
                value[WORD_W-1:0] <= lo_sum[WORD_W-1:0];
                if (long_mode)
                    value[2*WORD_W-1:WORD_W] <= hi_sum[WORD_W-1:0];
                wrap_q <= (long_mode ? hi_sum[WORD_W] : lo_sum[WORD_W])
                          && !load_lo && !load_hi;
            end
            if (load_lo)
                value[WORD_W-1:0] <= load_val;
            if (load_hi)
                value[2*WORD_W-1:WORD_W] <= load_val;
        end
    end

endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR  = 31,
    parameter bit WIDE_EVT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [6:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [6:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic [30:0] evt_i,
    output logic [31:0] wrap_o
);

    localparam int EVT_W = evt_width(WIDE_EVT);

    ctrl_t                        ctl;
    logic [SLOTS-1:0]             en_q;
    logic [SLOTS-1:0]             valid;
    logic [SLOTS-1:0]             en_eff;
    logic [SLOTS-1:0][EVT_W-1:0]  type_q;
    logic [CYC_IDX-1:0]           sw_hit;
    logic [NPAIR-1:0]             chained;
    logic                         clr_evt;
    logic                         clr_cyc;
    logic [SLOTS-1:0]             cnt_wr;
    logic                         cyc_hi_wr;

    logic [SLOTS-1:0][WORD_W-1:0] cnt_val;
    logic [2*WORD_W-1:0]          cyc_val;
    logic [SLOTS-1:0]             wrap_v;
    logic [CYC_IDX-1:0]           carry;
    logic [CYC_IDX-1:0]           link_hi;
    logic [SLOTS-1:0]             link_lo;

    evt_ctr_regs #(.NUM_CTR(NUM_CTR), .EVT_W(EVT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctl       (ctl),
        .en_q      (en_q),
        .valid     (valid),
        .en_eff    (en_eff),
        .type_q    (type_q),
        .sw_hit    (sw_hit),
        .chained   (chained),
        .clr_evt   (clr_evt),
        .clr_cyc   (clr_cyc),
        .cnt_wr    (cnt_wr),
        .cyc_hi_wr (cyc_hi_wr)
    );

    assign link_lo[CYC_IDX] = 1'b0;

    for (genvar i = 0; i < CYC_IDX; i++) begin : g_ctr
        if (i % 2 == 1 && i < NUM_CTR) begin : g_hi
            assign link_hi[i] = chained[i/2];
        end else begin : g_nohi
            assign link_hi[i] = 1'b0;
        end

        if (i % 2 == 0 && i + 1 < NUM_CTR) begin : g_lo
            assign link_lo[i] = chained[i/2];
        end else begin : g_nolo
            assign link_lo[i] = 1'b0;
        end

        if (i < NUM_CTR) begin : g_live
            logic cin;
            if (i % 2 == 1) begin : g_cin
                assign cin = carry[i-1];
            end else begin : g_nocin
                assign cin = 1'b0;
            end

            evt_ctr_slice u_slice (
                .clk       (clk),
                .rst       (rst),
                .count_en  (en_eff[i]),
                .evt       (evt_i[i]),
                .sw_hit    (sw_hit[i]),
                .link_hi   (link_hi[i]),
                .link_lo   (link_lo[i]),
                .carry_in  (cin),
                .load      (cnt_wr[i]),
                .clear     (clr_evt && valid[i]),
                .load_val  (wr_data),
                .value     (cnt_val[i]),
                .carry_out (carry[i]),
                .wrap_q    (wrap_v[i])
            );
        end else begin : g_absent
            assign cnt_val[i] = '0;
            assign carry[i]   = 1'b0;
            assign wrap_v[i]  = 1'b0;
        end
    end

    evt_ctr_cycle u_cycle (
        .clk       (clk),
        .rst       (rst),
        .count_en  (en_eff[CYC_IDX]),
        .long_mode (ctl.long_cyc),
        .load_lo   (cnt_wr[CYC_IDX]),
        .load_hi   (cyc_hi_wr),
        .clear     (clr_cyc),
        .load_val  (wr_data),
        .value     (cyc_val),
        .wrap_q    (wrap_v[CYC_IDX])
    );

    assign cnt_val[CYC_IDX] = cyc_val[WORD_W-1:0];
    assign wrap_o = wrap_v;

    wr_dec_t rdec;
    assign rdec = decode_addr(rd_addr);

    always_comb begin
        rd_data = '0;
        if (rdec.ctrl)
            rd_data = {23'b0, ctl.num, ctl.long_cyc, 2'b00, ctl.run};
        else if (rdec.en_set || rdec.en_clr)
            rd_data = en_q & valid;
        else if (rdec.swinc)
            rd_data = '0;
        else if (rdec.type_w)
            rd_data = valid[rdec.idx] ? WORD_W'(type_q[rdec.idx]) : '0;
        else if (rdec.cnt_w)
            rd_data = valid[rdec.idx] ? cnt_val[rdec.idx] : '0;
        else if (rdec.cyc_hi)
            rd_data = cyc_val[2*WORD_W-1:WORD_W];
    end

endmodule

// File: rtl/evt_ctr_chk.sv
module evt_ctr_chk
    import evt_ctr_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                run,
    input logic                long_cyc,
    input logic                clr_cyc,
    input logic                cyc_hi_wr,
    input logic [2*WORD_W-1:0] cyc_val,
    input logic [SLOTS-1:0]    lo_link,
    input logic [SLOTS-1:0]    valid,
    input logic [SLOTS-1:0]    wrap_o
);

    // R4: halted bank raises no wrap strobe
    p_halted_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        !run |=> (wrap_o == '0));

    // R9: low half of a chained pair never strobes
    p_chain_lo_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (|lo_link) |=> ((wrap_o & $past(lo_link)) == '0));

    // R10: in short mode the cycle high word holds unless written or cleared
    p_short_cycle_hi_r10: assert property (@(posedge clk) disable iff (rst)
        (!long_cyc && !cyc_hi_wr && !clr_cyc) |=> $stable(cyc_val[2*WORD_W-1:WORD_W]));

    // R11: cycle clear lands on the next edge
    p_cycle_clear_r11: assert property (@(posedge clk) disable iff (rst)
        clr_cyc |=> (cyc_val == '0));

    // R12: counters outside the count field never strobe
    p_invalid_no_wrap_r12: assert property (@(posedge clk) disable iff (rst)
        (valid != '1) |=> ((wrap_o & ~$past(valid)) == '0));

endmodule

bind evt_ctr_bank evt_ctr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (ctl.run),
    .long_cyc  (ctl.long_cyc),
    .clr_cyc   (clr_cyc),
    .cyc_hi_wr (cyc_hi_wr),
    .cyc_val   (cyc_val),
    .lo_link   (link_lo),
    .valid     (valid),
    .wrap_o    (wrap_o)
);

// File: tb/evt_ctr_bank_tb.sv
`timescale 1ns/1ps
module evt_ctr_bank_tb;

    localparam logic [6:0] A_CTL = 7'h00, A_ESET = 7'h01, A_ECLR = 7'h02, A_SW = 7'h03;
    localparam logic [6:0] A_TYP = 7'h20, A_CNT = 7'h40, A_CLO = 7'h5F, A_CHI = 7'h60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [30:0] evt_i = '0;
    logic [31:0] wrap_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    evt_ctr_bank u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .evt_i(evt_i), .wrap_o(wrap_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_rd(input string tag, input logic [6:0] a, input logic [31:0] exp);
        rd_addr = a;
        #0.5;
        check(tag, rd_data, exp);
    endtask

    task automatic pulse(input logic [30:0] m);
        @(negedge clk);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset;
        check_rd("R1 control", A_CTL, 32'h0000_01F0);
        check_rd("R1 enables", A_ESET, 32'h0);
        check_rd("R1 counter0", A_CNT, 32'h0);
        check_rd("R1 type3", A_TYP + 7'd3, 32'h0);
        check_rd("R1 cycle hi", A_CHI, 32'h0);
        check("R1 wrap", wrap_o, 32'h0);
    endtask

    task automatic t_type_mask;
        reg_wr(A_TYP + 7'd3, 32'hABCD_1234);
        check_rd("R2 type mask", A_TYP + 7'd3, 32'h0000_1234);
    endtask

    task automatic t_enable;
        reg_wr(A_ESET, 32'h8000_000F);
        check_rd("R3 set", A_ESET, 32'h8000_000F);
        reg_wr(A_ECLR, 32'h0000_0003);
        check_rd("R3 clear", A_ECLR, 32'h8000_000C);
        reg_wr(A_ECLR, 32'hFFFF_FFFF);
        check_rd("R3 clear all", A_ESET, 32'h0);
    endtask

    task automatic t_halt;
        reg_wr(A_ESET, 32'h1);
        pulse(31'h1);
        check_rd("R4 event while halted", A_CNT, 32'h0);
        reg_wr(A_SW, 32'h1);
        check_rd("R4 swinc while halted", A_CNT, 32'h0);
        check("R4 wrap while halted", wrap_o, 32'h0);
    endtask

    task automatic t_swinc;
        reg_wr(A_CTL, 32'h0000_01F1);
        reg_wr(A_SW, 32'h3);
        check_rd("R5 enabled swinc", A_CNT, 32'h1);
        check_rd("R5 disabled swinc", A_CNT + 7'd1, 32'h0);
        reg_wr(A_TYP + 7'd2, 32'h11);
        reg_wr(A_ESET, 32'h4);
        reg_wr(A_SW, 32'h4);
        check_rd("R5 wrong type swinc", A_CNT + 7'd2, 32'h0);
        pulse(31'h4);
        check_rd("R5 event any type", A_CNT + 7'd2, 32'h1);
    endtask

    task automatic t_wrap;
        reg_wr(A_CNT, 32'hFFFF_FFFF);
        reg_wr(A_SW, 32'h1);
        check_rd("R6 rolled value", A_CNT, 32'h0);
        check("R6 wrap strobe", wrap_o, 32'h0000_0001);
        @(negedge clk);
        check("R6 strobe one cycle", wrap_o, 32'h0);
    endtask

    task automatic t_sum;
        reg_wr(A_ESET, 32'h10);
        @(negedge clk);
        evt_i = 31'h10; wr_en = 1'b1; wr_addr = A_SW; wr_data = 32'h10;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0;
        check_rd("R7 summed step", A_CNT + 7'd4, 32'h2);
    endtask

    task automatic t_chain;
        reg_wr(A_TYP + 7'd7, 32'h0001_001E);
        check_rd("R2 chain code masked", A_TYP + 7'd7, 32'h0000_001E);
        reg_wr(A_ESET, 32'h40);
        reg_wr(A_CNT + 7'd6, 32'hFFFF_FFFF);
        pulse(31'h40);
        check("R8 unchained low strobes", wrap_o, 32'h0000_0040);
        check_rd("R8 unchained high idle", A_CNT + 7'd7, 32'h0);
        reg_wr(A_ESET, 32'h80);
        reg_wr(A_CNT + 7'd6, 32'hFFFF_FFFF);
        reg_wr(A_CNT + 7'd7, 32'h5);
        pulse(31'hC0);
        check("R9 no strobe on carry", wrap_o, 32'h0);
        check_rd("R9 low rolled", A_CNT + 7'd6, 32'h0);
        check_rd("R9 high took carry only", A_CNT + 7'd7, 32'h6);
        pulse(31'h80);
        check_rd("R9 high ignores own event", A_CNT + 7'd7, 32'h6);
        reg_wr(A_CNT + 7'd6, 32'hFFFF_FFFF);
        reg_wr(A_CNT + 7'd7, 32'hFFFF_FFFF);
        pulse(31'h40);
        check("R9 64-bit strobe on odd", wrap_o, 32'h0000_0080);
        check_rd("R9 high rolled", A_CNT + 7'd7, 32'h0);
    endtask

    task automatic t_cycle;
        reg_wr(A_CHI, 32'h5);
        reg_wr(A_CLO, 32'hFFFF_FFFE);
        reg_wr(A_ESET, 32'h8000_0000);
        @(negedge clk);
        @(negedge clk);
        check("R10 short strobe", wrap_o, 32'h8000_0000);
        check_rd("R10 short low", A_CLO, 32'h0);
        check_rd("R10 short high held", A_CHI, 32'h5);
        reg_wr(A_ECLR, 32'h8000_0000);
        reg_wr(A_CTL, 32'h0000_01F9);
        check_rd("R10 long mode bit", A_CTL, 32'h0000_01F9);
        reg_wr(A_CHI, 32'hFFFF_FFFF);
        reg_wr(A_CLO, 32'hFFFF_FFFE);
        reg_wr(A_ESET, 32'h8000_0000);
        @(negedge clk);
        @(negedge clk);
        check("R10 long strobe", wrap_o, 32'h8000_0000);
        check_rd("R10 long low", A_CLO, 32'h0);
        check_rd("R10 long high", A_CHI, 32'h0);
        reg_wr(A_ECLR, 32'h8000_0000);
    endtask

    task automatic t_clear;
        reg_wr(A_CLO, 32'h0000_1234);
        reg_wr(A_CNT + 7'd5, 32'h0000_0099);
        reg_wr(A_CTL, 32'h0000_01FB);
        check_rd("R11 event clear c5", A_CNT + 7'd5, 32'h0);
        check_rd("R11 event clear c2", A_CNT + 7'd2, 32'h0);
        check_rd("R11 cycle kept", A_CLO, 32'h0000_1234);
        check_rd("R11 action bits read 0", A_CTL, 32'h0000_01F9);
        reg_wr(A_CTL, 32'h0000_01FD);
        check_rd("R11 cycle cleared", A_CLO, 32'h0);
    endtask

    task automatic t_count_field;
        reg_wr(A_CTL, 32'h0000_01F1);
        reg_wr(A_CNT + 7'd5, 32'h0000_0055);
        reg_wr(A_ESET, 32'h20);
        reg_wr(A_CTL, 32'h0000_0041);
        check_rd("R12 control N", A_CTL, 32'h0000_0041);
        check_rd("R12 invalid reads 0", A_CNT + 7'd5, 32'h0);
        reg_wr(A_CNT + 7'd5, 32'h0000_0077);
        reg_wr(A_TYP + 7'd5, 32'h0000_0011);
        pulse(31'h20);
        check("R12 no strobe", wrap_o, 32'h0);
        reg_wr(A_CTL, 32'h0000_0001);
        check_rd("R12 N zero hides c0", A_CNT, 32'h0);
        check_rd("R12 N zero cycle visible", A_CHI, 32'h0);
        reg_wr(A_CTL, 32'h0000_01F1);
        check_rd("R12 value untouched", A_CNT + 7'd5, 32'h0000_0055);
        check_rd("R12 type untouched", A_TYP + 7'd5, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_type_mask();
        t_enable();
        t_halt();
        t_swinc();
        t_wrap();
        t_sum();
        t_chain();
        t_cycle();
        t_clear();
        t_count_field();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule